// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block shares one bus among a set of devices grouped into priority levels. Every level has one request line, formed as the wired OR of its devices' requests, and one grant line. A grant entering a level travels along that level's devices in index order. The first device it meets that is requesting keeps the grant and stops it. Devices further down the chain never see it. Position in the chain is therefore the priority inside a level, and a device near the end can be starved by the devices ahead of it.

The central state machine samples the level request lines while the bus is free. It raises the grant line of the most important requesting level for one cycle and latches the device that caught the grant as the owner. It then waits until the shared release line is pulsed before it arbitrates again. When overlap mode is on, the machine also arbitrates while the bus is held. The device chosen this way is recorded as the pending next owner and takes the bus in the cycle after the release, so no idle arbitration cycles are lost. Device bit `i` in every device vector belongs to level `i / ND`, chain position `i % ND`.

Top module: `daisy_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to its free state, and from then on `level_grant`, `dev_take`, `dev_own`, `dev_next` and `bus_busy` are all zero.
- R2: When the bus is free and any request is seen at a rising edge, exactly one `level_grant` bit is high during the next cycle. The device that caught the grant appears on `dev_own` from the cycle after that.
- R3: Level 0 is the most important level. A grant goes only to the lowest-numbered level that has a request, and at most one `level_grant` bit is ever high.
- R4: Inside the granted level, the grant passes devices in increasing chain position. `dev_take` shows, in the same cycle, only the requesting device with the lowest position. No other device of any level sees the grant.
- R5: At most one bit of `dev_own` is set, at most one bit of `dev_next` is set, and `bus_busy` is high exactly when `dev_own` is nonzero.
- R6: The owner stays unchanged until `rel_line` is sampled high. After a release with no pending next owner, `dev_own` and `level_grant` are zero in the following cycle.
- R7: With `overlap_en` low, requests that arrive while the bus is owned raise no grant line until the bus has been released.
- R8: With `overlap_en` high, a request seen while the bus is owned raises the grant line of its level in the next cycle. The catcher appears on `dev_next` one cycle later, and it becomes `dev_own` in the cycle after `rel_line` is sampled high.
- R9: The request of the current owner and the request of the pending next owner take no part in arbitration. A lower level can therefore win even while the owner keeps requesting.
- R10: If no device of the granted level is still requesting during the grant cycle, the grant lapses with no new owner. The bus then returns to free, or, in overlap mode, stays with its current owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| overlap_en | input | 1 | Enables arbitration while the bus is owned |
| dev_req | input | NL*ND | Per-device request, bit = level*ND + position |
| rel_line | input | 1 | Shared release line pulsed by the owner when it is done |
| level_grant | output | NL | Grant line driven into the first device of each level |
| dev_take | output | NL*ND | Device that catches the rippling grant this cycle |
| dev_own | output | NL*ND | Current owner of the bus, one-hot or zero |
| dev_next | output | NL*ND | Next owner chosen in overlap mode, one-hot or zero |
| bus_busy | output | 1 | High while the bus has an owner |

## Verification
A fixed sequence first sends two requests on one level, which separates lowest-position-wins from any other order. It then sends requests on two levels at once, which shows that level order beats chain order. An owner that keeps requesting in overlap mode shows whether its own request is masked. A request dropped during the grant cycle exposes a grant that lapses. A long random phase then toggles overlap mode every few hundred cycles and mixes dense and sparse request patterns with random release pulses. This reaches the release-during-preselection case, back-to-back handovers and spurious releases. A behavioural model using integer indices predicts every output on every cycle.

// File: rtl/daisy_arb_pkg.sv
// Package: shared types for the daisy-chain arbiter.
// Holds the state encoding used by the arbiter's control machine.
package daisy_arb_pkg;

    // Control states: free, grant rippling, owned, owned with overlapped arbitration
    typedef enum logic [1:0] {
        ARB_FREE   = 2'd0,
        ARB_GRANT  = 2'd1,
        ARB_OWNED  = 2'd2,
        ARB_PRESEL = 2'd3
    } arb_state_t;

endpackage

// File: rtl/chain_cell.sv
// Module: chain_cell
// One device position in a grant chain. A requesting device keeps an
// incoming grant; an idle one hands it on to its neighbour.
// Assumes: purely combinational, no storage.
module chain_cell (
    input  logic gnt_in,
    input  logic want,
    output logic caught,
    output logic gnt_out
);

    // Keep or forward the grant
    always_comb begin
        caught  = gnt_in & want;
        gnt_out = gnt_in & ~want;
    end

endmodule

// File: rtl/chain_level.sv
// Module: chain_level
// A row of ND chain cells sharing one grant line. The grant enters position
// 0 and ripples upward; tail reports that it left the row uncaught.
// Assumes: ND >= 1; the ripple settles within one clock cycle.
module chain_level #(
    parameter int ND = 4
) (
    input  logic          gnt_line,
    input  logic [ND-1:0] want,
    output logic [ND-1:0] caught,
    output logic          tail
);

    logic [ND:0] ripple;

    // Feed the grant line into the first position
    assign ripple[0] = gnt_line;

    genvar p;
    generate
        for (p = 0; p < ND; p++) begin : g_pos
            chain_cell u_cell (
                .gnt_in  (ripple[p]),
                .want    (want[p]),
                .caught  (caught[p]),
                .gnt_out (ripple[p+1])
            );
        end
    endgenerate

    // Grant that fell off the end of the chain
    assign tail = ripple[ND];

endmodule

// File: rtl/level_pick.sv
// Module: level_pick
// Chooses the lowest-numbered level whose wired-OR request is active.
// Assumes: level 0 is the most important level.
module level_pick #(
    parameter int NL = 2,
    parameter int LW = 1
) (
    input  logic [NL-1:0] lvl_any,
    output logic          found,
    output logic [LW-1:0] pick
);

    // Priority scan from the least to the most important level
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int l = NL - 1; l >= 0; l--) begin
            if (lvl_any[l]) begin
                found = 1'b1;
                pick  = LW'(l);
            end
        end
    end

endmodule

// File: rtl/daisy_arbiter.sv
// Module: daisy_arbiter
// Central arbiter for NL priority levels of ND chained devices each. It
// raises one level's grant line for a cycle, latches the device that caught
// it as the owner, and waits for the shared release line. With overlap_en it
// preselects the next owner while the bus is still held.
// Assumes: the owner pulses rel_line once when done; the grant ripple is
// combinational.
module daisy_arbiter
    import daisy_arb_pkg::*;
#(
    parameter int NL = 2,
    parameter int ND = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             overlap_en,
    input  logic [NL*ND-1:0] dev_req,
    input  logic             rel_line,
    output logic [NL-1:0]    level_grant,
    output logic [NL*ND-1:0] dev_take,
    output logic [NL*ND-1:0] dev_own,
    output logic [NL*ND-1:0] dev_next,
    output logic             bus_busy
);

    localparam int NDEV = NL * ND;
    localparam int LW   = (NL > 1) ? $clog2(NL) : 1;

    arb_state_t        state_q;
    logic [LW-1:0]     lvl_q;
    logic [NDEV-1:0]   own_q;
    logic [NDEV-1:0]   nxt_q;

    logic [NDEV-1:0]   live_req;
    logic [NL-1:0]     lvl_any;
    logic [NL-1:0]     tails;
    logic              found;
    logic [LW-1:0]     pick;
    logic              drive_gnt;
    logic              caught_any;

    // Owner and pending owner stay out of arbitration
    assign live_req = dev_req & ~own_q & ~nxt_q;

    // Grant line is driven in a grant cycle, normal or overlapped
    always_comb begin
        drive_gnt = (state_q == ARB_GRANT) ||
                    ((state_q == ARB_PRESEL) && (nxt_q == '0));
    end

    genvar l;
    generate
        for (l = 0; l < NL; l++) begin : g_lvl
            // Wired OR of this level's requests
            assign lvl_any[l]     = |live_req[l*ND +: ND];
            // Only the latched level receives the grant
            assign level_grant[l] = drive_gnt && (lvl_q == LW'(l));

            chain_level #(.ND(ND)) u_chain (
                .gnt_line (level_grant[l]),
                .want     (live_req[l*ND +: ND]),
                .caught   (dev_take[l*ND +: ND]),
                .tail     (tails[l])
            );
        end
    endgenerate

    level_pick #(.NL(NL), .LW(LW)) u_pick (
        .lvl_any (lvl_any),
        .found   (found),
        .pick    (pick)
    );

    // A grant was caught if the driven line did not reach its tail
    assign caught_any = |(level_grant & ~tails);

    // Control machine: arbitration, ownership and handover
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
            lvl_q   <= '0;
            own_q   <= '0;
            nxt_q   <= '0;
        end else begin
            case (state_q)
                ARB_FREE: begin
                    if (found) begin
                        lvl_q   <= pick;
                        state_q <= ARB_GRANT;
                    end
                end
                ARB_GRANT: begin
                    if (caught_any) begin
                        own_q   <= dev_take;
                        state_q <= ARB_OWNED;
                    end else begin
                        state_q <= ARB_FREE;
                    end
                end
                ARB_OWNED: begin
                    if (rel_line) begin
                        own_q   <= '0;
                        state_q <= ARB_FREE;
                    end else if (overlap_en && found) begin
                        lvl_q   <= pick;
                        state_q <= ARB_PRESEL;
                    end
                end
                ARB_PRESEL: begin
                    if (nxt_q == '0) begin
                        if (rel_line) begin
                            own_q   <= caught_any ? dev_take : '0;
                            state_q <= caught_any ? ARB_OWNED : ARB_FREE;
                        end else if (caught_any) begin
                            nxt_q <= dev_take;
                        end else begin
                            state_q <= ARB_OWNED;
                        end
                    end else if (rel_line) begin
                        own_q   <= nxt_q;
                        nxt_q   <= '0;
                        state_q <= ARB_OWNED;
                    end
                end
                default: state_q <= ARB_FREE;
            endcase
        end
    end

    // Registered ownership seen at the ports
    assign dev_own  = own_q;
    assign dev_next = nxt_q;
    assign bus_busy = (state_q == ARB_OWNED) || (state_q == ARB_PRESEL);

endmodule

// File: rtl/daisy_arbiter_chk.sv
// Module: daisy_arbiter_chk
// Port-level temporal checks for daisy_arbiter, attached by bind.
// Assumes: same parameters as the bound instance.
module daisy_arbiter_chk #(
    parameter int NL = 2,
    parameter int ND = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             overlap_en,
    input logic [NL*ND-1:0] dev_req,
    input logic             rel_line,
    input logic [NL-1:0]    level_grant,
    input logic [NL*ND-1:0] dev_take,
    input logic [NL*ND-1:0] dev_own,
    input logic [NL*ND-1:0] dev_next,
    input logic             bus_busy
);

    // R2
    free_req_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && level_grant == '0 && |dev_req) |=> $countones(level_grant) == 1);

    // R3
    one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(level_grant));

    // R4
    take_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_take) |-> ($onehot0(dev_take) && |level_grant));

    // R5
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_own) && $onehot0(dev_next) && (bus_busy == (|dev_own)));

    // R6
    owner_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_own && !rel_line) |=> dev_own == $past(dev_own));

    // R6
    release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && rel_line && dev_next == '0 && level_grant == '0)
        |=> (dev_own == '0 && level_grant == '0));

    // R7
    no_overlap_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && !overlap_en && level_grant == '0 && !rel_line) |=> level_grant == '0);

    // R8
    handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_next && rel_line) |=> dev_own == $past(dev_next));

endmodule

bind daisy_arbiter daisy_arbiter_chk #(.NL(NL), .ND(ND)) u_chk (.*);

// File: tb/daisy_arbiter_bench.sv
// Bench: directed sequence plus random traffic against a behavioural model
// that tracks owner, next owner and granted level as integer indices.
module daisy_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NL   = 2;
    localparam int ND   = 4;
    localparam int NDEV = NL * ND;

    logic            clk;
    logic            rst_n;
    logic            overlap_en;
    logic [NDEV-1:0] dev_req;
    logic            rel_line;
    logic [NL-1:0]   level_grant;
    logic [NDEV-1:0] dev_take;
    logic [NDEV-1:0] dev_own;
    logic [NDEV-1:0] dev_next;
    logic            bus_busy;

    int checks = 0;
    int errors = 0;

    // Model: ms 0 free, 1 granting, 2 owned, 3 owned with preselection
    int ms, ml, mo, mn;

    daisy_arbiter #(.NL(NL), .ND(ND)) u_daisy_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .overlap_en  (overlap_en),
        .dev_req     (dev_req),
        .rel_line    (rel_line),
        .level_grant (level_grant),
        .dev_take    (dev_take),
        .dev_own     (dev_own),
        .dev_next    (dev_next),
        .bus_busy    (bus_busy)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit live(int i);
        return dev_req[i] && (i != mo) && (i != mn);
    endfunction

    function automatic bit gnt_active();
        return (ms == 1) || (ms == 3 && mn < 0);
    endfunction

    function automatic int m_take();
        if (!gnt_active()) return -1;
        for (int d = 0; d < ND; d++)
            if (live(ml * ND + d)) return ml * ND + d;
        return -1;
    endfunction

    function automatic int m_sel();
        for (int l = 0; l < NL; l++)
            for (int d = 0; d < ND; d++)
                if (live(l * ND + d)) return l;
        return -1;
    endfunction

    function automatic logic [NDEV-1:0] bit_of(int i);
        logic [NDEV-1:0] v = '0;
        if (i >= 0) v[i] = 1'b1;
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive inputs away from the edge, then compare every output to the model
    task automatic drive(logic [NDEV-1:0] req, logic rel, logic ov);
        logic [NL-1:0] lg_e;
        @(negedge clk);
        dev_req    = req;
        rel_line   = rel;
        overlap_en = ov;
        #1;
        lg_e = '0;
        if (gnt_active()) lg_e[ml] = 1'b1;
        chk("R3 level_grant", 32'(level_grant), 32'(lg_e));
        chk("R4 dev_take",    32'(dev_take),    32'(bit_of(m_take())));
        chk("R6 dev_own",     32'(dev_own),     32'(bit_of(mo)));
        chk("R8 dev_next",    32'(dev_next),    32'(bit_of(mn)));
        chk("R5 bus_busy",    32'(bus_busy),    32'(ms == 2 || ms == 3));
    endtask

    // Clock edge: advance the model with the inputs the design samples
    task automatic adv();
        int t;
        int s;
        @(posedge clk);
        t = m_take();
        s = m_sel();
        case (ms)
            0: if (s >= 0) begin ml = s; ms = 1; end
            1: if (t >= 0) begin mo = t; ms = 2; end else ms = 0;
            2: if (rel_line) begin mo = -1; ms = 0; end
               else if (overlap_en && s >= 0) begin ml = s; ms = 3; end
            default: begin
                if (mn < 0) begin
                    if (rel_line) begin mo = t; ms = (t >= 0) ? 2 : 0; end
                    else if (t >= 0) mn = t;
                    else ms = 2;
                end else if (rel_line) begin
                    mo = mn; mn = -1; ms = 2;
                end
            end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dev_req = '0; rel_line = 1'b0; overlap_en = 1'b0;
        ms = 0; ml = 0; mo = -1; mn = -1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        dev_req = '1; rel_line = 1'b1; overlap_en = 1'b1;
        #1;
        // R1: reset holds every output at zero even with all requests high
        chk("R1 level_grant", 32'(level_grant), 0);
        chk("R1 dev_take",    32'(dev_take),    0);
        chk("R1 dev_own",     32'(dev_own),     0);
        chk("R1 dev_next",    32'(dev_next),    0);
        chk("R1 bus_busy",    32'(bus_busy),    0);
        @(posedge clk);
        @(negedge clk);
        dev_req = '0; rel_line = 1'b0; overlap_en = 1'b0; rst_n = 1'b1;

        // R2, R4: two requests on level 1 at positions 1 and 2
        drive(8'h60, 0, 0); adv();
        drive(8'h60, 0, 0);
        chk("R2 grant line level 1", 32'(level_grant), 32'h2);
        chk("R4 lowest position takes", 32'(dev_take), 32'h20);
        adv();
        // R7: level 0 request while owned, overlap off
        drive(8'h41, 0, 0);
        chk("R2 owner latched", 32'(dev_own), 32'h20);
        chk("R7 no grant while owned", 32'(level_grant), 0);
        adv();
        drive(8'h61, 1, 0);
        chk("R7 no grant at release", 32'(level_grant), 0);
        adv();
        drive(8'h41, 0, 0);
        chk("R6 free after release", 32'(dev_own), 0);
        adv();
        // R3: levels 0 and 1 both request, level 0 wins
        drive(8'h41, 0, 0);
        chk("R3 level 0 wins", 32'(level_grant), 32'h1);
        chk("R3 level 0 device takes", 32'(dev_take), 32'h01);
        adv();
        // R9: owner keeps requesting in overlap mode, level 1 is preselected
        drive(8'h41, 0, 1);
        chk("R9 owner", 32'(dev_own), 32'h01);
        adv();
        drive(8'h41, 0, 1);
        chk("R9 owner request masked", 32'(level_grant), 32'h2);
        chk("R8 overlapped take", 32'(dev_take), 32'h40);
        adv();
        drive(8'h41, 0, 1);
        chk("R8 next owner", 32'(dev_next), 32'h40);
        chk("R8 owner kept", 32'(dev_own), 32'h01);
        adv();
        drive(8'h41, 1, 1); adv();
        drive(8'h00, 1, 0);
        chk("R8 handover", 32'(dev_own), 32'h40);
        chk("R8 next cleared", 32'(dev_next), 0);
        adv();
        // R10: request withdrawn during the grant cycle
        drive(8'h08, 0, 0); adv();
        drive(8'h00, 0, 0);
        chk("R10 grant driven", 32'(level_grant), 32'h1);
        chk("R10 nobody takes", 32'(dev_take), 0);
        adv();
        drive(8'h00, 0, 0);
        chk("R10 bus stays free", 32'(bus_busy), 0);
        adv();

        // Random traffic, overlap mode toggled every 500 cycles
        for (int n = 0; n < 4000; n++) begin
            logic [NDEV-1:0] r;
            r = NDEV'($urandom);
            if (n % 1000 >= 500) r = r & NDEV'($urandom);
            drive(r, ($urandom % 3) == 0, ((n / 500) % 2) == 1);
            adv();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule